// File: doc/BRIEF.md
# Self-Recovering Serial Command Decoder

This block receives a command stream one bit per clock on a single serial line and turns it into single-cycle strobes: sync, global reset, register write, register read and trigger. A register write delivers an address and a data word; a register read delivers an address. Each trigger also produces a level-1 pulse for the front-end chips. The pulse comes from a register, so the receiving side can sample it on the rising clock edge.

The decoder must recover by itself from whatever state it powers up in, with no help from a pin reset. A free-running watchdog counter runs alongside it. Any malformed header, unknown opcode or illegal state encoding sends the decoder into a lockout state. It leaves that state only on the clock edge where the counter reads zero, so it is back in idle within 65536 cycles. The global reset command is only a strobe for the other blocks and leaves the decoder alone. The active-low pin reset clears every flip-flop at once and is kept for test.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While the asynchronous active-low reset `rst_ni` is low, every output is 0, including the address and data outputs. The watchdog counter and the decoder state are cleared too. After release, commands decode normally.
- R2: The watchdog counter is 16 bits wide and is never touched by a command. It reads 0 at the first rising edge after reset release and advances by one at every edge, so lockout exits fall at edges 65536·k after release.
- R3: The serial pattern 1101 starting from idle raises `trig_o` for one cycle, in the cycle after its last bit.
- R4: `l1_o` is a registered single-cycle pulse. It is high in the cycle after the edge that comes 8 edges after the edge that sampled the first trigger bit.
- R5: The header 1011 followed by a 4-bit opcode (MSB first) raises `sync_o` for opcode 0001 and `gres_o` for opcode 0010, in the cycle after the last opcode bit.
- R6: Opcode 0100 is followed by a 4-bit address and then a 16-bit data word, both MSB first. It raises `wr_o` after the last data bit, and in that same cycle `addr_o`/`data_o` take the new values and then hold them.
- R7: Opcode 1000 is followed by a 4-bit address, MSB first. It raises `rd_o` after the last address bit, updates `addr_o` and leaves `data_o` unchanged.
- R8: A global reset command does not disturb the decoder. A command whose first bit arrives on the edge right after the last global-reset bit is decoded.
- R9: Any prefix other than 1011 or 1101 (seen as 100, 111, 1010 or 1100), or any unknown opcode, puts the decoder in lockout. While locked, every command is ignored, global reset included, and no strobe or level-1 pulse comes from it.
- R10: Lockout ends only on the edge where the watchdog reads 0. The bit sampled on that edge is ignored, and a command may begin on the next edge.
- R11: Zeros on the line in idle have no effect. At most one decoded strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low pin reset |
| cmd_i | input | 1 | Serial command bit, sampled on each rising edge |
| sync_o | output | 1 | Sync command strobe |
| gres_o | output | 1 | Global reset strobe for the other blocks |
| wr_o | output | 1 | Register write strobe |
| rd_o | output | 1 | Register read strobe |
| trig_o | output | 1 | Trigger command strobe |
| l1_o | output | 1 | Level-1 pulse toward the front ends |
| addr_o | output | 4 | Register address of the last read or write |
| data_o | output | 16 | Data word of the last write |

## Verification
Two pairs of functions can land in the same cycle. The first is a lockout exit and the start of a command. The bench tracks the watchdog in its own model, waits until the counter is about to read zero, and puts a 1 on the line at exactly that edge, followed by a trigger pattern. The stray 1 must be ignored and the trigger must decode. The second pair is a level-1 pulse and a new trigger strobe. Sending a trigger, one idle zero and a second trigger makes the first trigger's level-1 pulse and the second trigger's strobe fall in the same cycle, and both are required high together there.

// File: rtl/serial_cmd_decoder_pkg.sv
package serial_cmd_decoder_pkg;

   // Length of the fixed command header, and of the trigger pattern.
   localparam int unsigned HDR_LEN = 4;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_H1   = 4'd1,
      ST_H10  = 4'd2,
      ST_H11  = 4'd3,
      ST_H101 = 4'd4,
      ST_H110 = 4'd5,
      ST_OPC  = 4'd6,
      ST_ADDR = 4'd7,
      ST_DATA = 4'd8,
      ST_LOCK = 4'd9
   } dec_state_e;

   typedef struct packed {
      logic sync;
      logic gres;
      logic wr;
      logic rd;
      logic trig;
   } strobe_t;

endpackage

// File: rtl/serial_cmd_decoder_wdog.sv
module serial_cmd_decoder_wdog #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   // Free running: no command input reaches this counter.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = (cnt_q == '0);

endmodule

// File: rtl/serial_cmd_decoder_fsm.sv
module serial_cmd_decoder_fsm
   import serial_cmd_decoder_pkg::*;
#(
   parameter int unsigned      ADDR_W  = 4,
   parameter int unsigned      DATA_W  = 16,
   parameter int unsigned      OPC_W   = 4,
   parameter logic [OPC_W-1:0] OP_SYNC = 4'b0001,
   parameter logic [OPC_W-1:0] OP_GRES = 4'b0010,
   parameter logic [OPC_W-1:0] OP_WR   = 4'b0100,
   parameter logic [OPC_W-1:0] OP_RD   = 4'b1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_i,
   input  logic              wrap_i,
   output strobe_t           stb_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output dec_state_e        state_o
);

   localparam int unsigned SH_W    = DATA_W;
   localparam int unsigned LEN_MAX = (DATA_W > ADDR_W) ?
                                     ((DATA_W > OPC_W) ? DATA_W : OPC_W) :
                                     ((ADDR_W > OPC_W) ? ADDR_W : OPC_W);
   localparam int unsigned BCNT_W  = $clog2(LEN_MAX + 1);

   dec_state_e        state_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [SH_W-2:0]   sh_q;
   logic              is_wr_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   strobe_t           stb_q;

   logic [SH_W-1:0]   shin;
   logic              last_bit;
   logic [OPC_W-1:0]  opc_fld;
   logic [ADDR_W-1:0] addr_fld;

   always_comb begin
      shin     = {sh_q, cmd_i};
      last_bit = (bcnt_q == BCNT_W'(1));
      opc_fld  = shin[OPC_W-1:0];
      addr_fld = shin[ADDR_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         bcnt_q      <= '0;
         sh_q        <= '0;
         is_wr_q     <= 1'b0;
         pend_addr_q <= '0;
         addr_q      <= '0;
         data_q      <= '0;
         stb_q       <= '0;
      end else begin
         stb_q <= '0;
         sh_q  <= shin[SH_W-2:0];
         case (state_q)
            ST_IDLE: begin
               if (cmd_i) state_q <= ST_H1;
            end
            ST_H1:  state_q <= cmd_i ? ST_H11 : ST_H10;
            ST_H10: state_q <= cmd_i ? ST_H101 : ST_LOCK;
            ST_H11: state_q <= cmd_i ? ST_LOCK : ST_H110;
            ST_H101: begin
               if (cmd_i) begin
                  state_q <= ST_OPC;
                  bcnt_q  <= BCNT_W'(OPC_W);
               end else begin
                  state_q <= ST_LOCK;
               end
            end
            ST_H110: begin
               if (cmd_i) begin
                  stb_q.trig <= 1'b1;
                  state_q    <= ST_IDLE;
               end else begin
                  state_q <= ST_LOCK;
               end
            end
            ST_OPC: begin
               if (!last_bit) begin
                  bcnt_q <= bcnt_q - 1'b1;
               end else if (opc_fld == OP_SYNC) begin
                  stb_q.sync <= 1'b1;
                  state_q    <= ST_IDLE;
               end else if (opc_fld == OP_GRES) begin
                  // Strobe only: the decoder's own state is untouched.
                  stb_q.gres <= 1'b1;
                  state_q    <= ST_IDLE;
               end else if (opc_fld == OP_WR || opc_fld == OP_RD) begin
                  is_wr_q <= (opc_fld == OP_WR);
                  bcnt_q  <= BCNT_W'(ADDR_W);
                  state_q <= ST_ADDR;
               end else begin
                  state_q <= ST_LOCK;
               end
            end
            ST_ADDR: begin
               if (!last_bit) begin
                  bcnt_q <= bcnt_q - 1'b1;
               end else if (is_wr_q) begin
                  pend_addr_q <= addr_fld;
                  bcnt_q      <= BCNT_W'(DATA_W);
                  state_q     <= ST_DATA;
               end else begin
                  addr_q   <= addr_fld;
                  stb_q.rd <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_DATA: begin
               if (!last_bit) begin
                  bcnt_q <= bcnt_q - 1'b1;
               end else begin
                  addr_q   <= pend_addr_q;
                  data_q   <= shin;
                  stb_q.wr <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_LOCK: begin
               if (wrap_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_LOCK;
         endcase
      end
   end

   assign stb_o   = stb_q;
   assign addr_o  = addr_q;
   assign data_o  = data_q;
   assign state_o = state_q;

endmodule

// File: rtl/serial_cmd_decoder_l1.sv
module serial_cmd_decoder_l1 #(
   parameter int unsigned DEPTH = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic l1_o
);

   generate
      if (DEPTH == 1) begin : g_single
         logic l1_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) l1_q <= 1'b0;
            else         l1_q <= trig_i;
         end
         assign l1_o = l1_q;
      end else begin : g_chain
         logic [DEPTH-1:0] pipe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pipe_q <= '0;
            else         pipe_q <= {pipe_q[DEPTH-2:0], trig_i};
         end
         assign l1_o = pipe_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
   import serial_cmd_decoder_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned OPC_W    = 4,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned L1_DELAY = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_i,
   output logic              sync_o,
   output logic              gres_o,
   output logic              wr_o,
   output logic              rd_o,
   output logic              trig_o,
   output logic              l1_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   // Stages after the trigger strobe register.
   localparam int unsigned L1_DEPTH = L1_DELAY - (HDR_LEN - 1);

   generate
      if (L1_DELAY < HDR_LEN) begin : g_bad_l1
         $error("L1_DELAY must cover the trigger pattern length");
      end
      if (DATA_W <= ADDR_W || DATA_W <= OPC_W) begin : g_bad_w
         $error("DATA_W must exceed ADDR_W and OPC_W");
      end
      if (OPC_W < 3 || CNT_W < 2) begin : g_bad_o
         $error("OPC_W or CNT_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] wd_cnt;
   logic             wd_wrap;
   strobe_t          stb;
   dec_state_e       fsm_state;

   serial_cmd_decoder_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (wd_cnt),
      .wrap_o (wd_wrap)
   );

   serial_cmd_decoder_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OPC_W  (OPC_W),
      .OP_SYNC(OPC_W'(1)),
      .OP_GRES(OPC_W'(2)),
      .OP_WR  (OPC_W'(4)),
      .OP_RD  (OPC_W'(8))
   ) u_fsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd_i),
      .wrap_i (wd_wrap),
      .stb_o  (stb),
      .addr_o (addr_o),
      .data_o (data_o),
      .state_o(fsm_state)
   );

   serial_cmd_decoder_l1 #(.DEPTH(L1_DEPTH)) u_l1 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (stb.trig),
      .l1_o   (l1_o)
   );

   assign sync_o = stb.sync;
   assign gres_o = stb.gres;
   assign wr_o   = stb.wr;
   assign rd_o   = stb.rd;
   assign trig_o = stb.trig;

endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk
   import serial_cmd_decoder_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cmd_i,
   input logic             sync_i,
   input logic             gres_i,
   input logic             wr_i,
   input logic             rd_i,
   input logic             trig_i,
   input logic             l1_i,
   input dec_state_e       state_i,
   input logic [CNT_W-1:0] cnt_i
);

   // Triggers issued whose level-1 pulse has not yet appeared.
   logic [3:0] pend_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= pend_q + 4'(trig_i) - 4'(l1_i);
   end

   AST_WDOG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (cnt_i == $past(cnt_i) + 1'b1)); // R2

   AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_LOCK && cnt_i != '0) |=> (state_i == ST_LOCK)); // R10

   AST_LOCK_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_LOCK && cnt_i == '0) |=> (state_i == ST_IDLE)); // R10

   AST_LOCK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_LOCK) |=> !(sync_i || gres_i || wr_i || rd_i || trig_i)); // R9

   AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sync_i, gres_i, wr_i, rd_i, trig_i})); // R11

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_IDLE && !cmd_i) |=> (state_i == ST_IDLE)); // R11

   AST_GRES_KEEPS_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gres_i |-> (state_i == ST_IDLE)); // R8

   AST_L1_FROM_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1_i |-> (pend_q != '0)); // R4

   AST_L1_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1_i |=> !l1_i); // R4

endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .cmd_i  (cmd_i),
   .sync_i (sync_o),
   .gres_i (gres_o),
   .wr_i   (wr_o),
   .rd_i   (rd_o),
   .trig_i (trig_o),
   .l1_i   (l1_o),
   .state_i(fsm_state),
   .cnt_i  (wd_cnt)
);

// File: tb/serial_cmd_decoder_tb_top.sv
module serial_cmd_decoder_tb_top;

   localparam int AW = 4;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd = 1'b0;
   logic sync_o, gres_o, wr_o, rd_o, trig_o, l1_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] data_o;

   always #4 clk = ~clk;

   serial_cmd_decoder dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd),
      .sync_o(sync_o), .gres_o(gres_o), .wr_o(wr_o), .rd_o(rd_o),
      .trig_o(trig_o), .l1_o(l1_o), .addr_o(addr_o), .data_o(data_o)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // ---------------- behavioural reference model ----------------
   int  m_mode = 0;          // 0 idle, 1 collecting, 2 locked
   int  m_wd = 0;            // watchdog value seen by the next edge
   int  m_cyc = 0;
   int  m_cur = 0;
   int  m_start = 0;
   int  m_op = 0;
   bit  m_q[$];
   int  m_l1q[$];
   bit  e_sync = 0, e_gres = 0, e_wr = 0, e_rd = 0, e_trig = 0, e_l1 = 0;
   int  e_addr = 0, e_data = 0;

   function automatic int qval(int from, int n);
      int v = 0;
      for (int i = from; i < from + n; i++) v = (v << 1) | int'(m_q[i]);
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_wd = 0; m_cyc = 0;
         m_q.delete(); m_l1q.delete();
         e_sync = 0; e_gres = 0; e_wr = 0; e_rd = 0; e_trig = 0; e_l1 = 0;
         e_addr = 0; e_data = 0;
      end else begin
         m_cyc++;
         m_cur = m_wd;
         m_wd = (m_wd + 1) % 65536;
         e_sync = 0; e_gres = 0; e_wr = 0; e_rd = 0; e_trig = 0;
         e_l1 = (m_l1q.size() > 0 && m_l1q[0] == m_cyc);
         if (e_l1) void'(m_l1q.pop_front());
         if (m_mode == 0) begin
            if (cmd) begin
               m_q.delete(); m_q.push_back(1'b1);
               m_start = m_cyc; m_mode = 1;
            end
         end else if (m_mode == 2) begin
            if (m_cur == 0) m_mode = 0;
         end else begin
            m_q.push_back(cmd);
            if (m_q.size() == 3 && qval(0, 3) != 5 && qval(0, 3) != 6) m_mode = 2;
            else if (m_q.size() == 4) begin
               if (qval(0, 4) == 13) begin
                  e_trig = 1; m_l1q.push_back(m_start + 8); m_mode = 0;
               end else if (qval(0, 4) != 11) m_mode = 2;
            end else if (m_q.size() == 8) begin
               m_op = qval(4, 4);
               if (m_op == 1) begin e_sync = 1; m_mode = 0; end
               else if (m_op == 2) begin e_gres = 1; m_mode = 0; end
               else if (m_op != 4 && m_op != 8) m_mode = 2;
            end else if (m_q.size() == 8 + AW && m_op == 8) begin
               e_rd = 1; e_addr = qval(8, AW); m_mode = 0;
            end else if (m_q.size() == 8 + AW + DW) begin
               e_wr = 1; e_addr = qval(8, AW); e_data = qval(8 + AW, DW); m_mode = 0;
            end
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   int seen_strobes = 0;
   int seen_trig = 0;
   int seen_sync = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(sync_o == e_sync, "R5", "sync_o", sync_o, e_sync);
         chk(gres_o == e_gres, "R5", "gres_o", gres_o, e_gres);
         chk(wr_o == e_wr, "R6", "wr_o", wr_o, e_wr);
         chk(rd_o == e_rd, "R7", "rd_o", rd_o, e_rd);
         chk(trig_o == e_trig, "R3", "trig_o", trig_o, e_trig);
         chk(l1_o == e_l1, "R4", "l1_o", l1_o, e_l1);
         chk(int'(addr_o) == e_addr, "R6/R7", "addr_o", addr_o, e_addr);
         chk(int'(data_o) == e_data, "R6", "data_o", data_o, e_data);
         chk($countones({sync_o, gres_o, wr_o, rd_o, trig_o}) <= 1, "R11",
             "strobe count", $countones({sync_o, gres_o, wr_o, rd_o, trig_o}), 1);
         seen_strobes += int'(sync_o) + int'(gres_o) + int'(wr_o) + int'(rd_o)
                         + int'(trig_o) + int'(l1_o);
         seen_trig += int'(trig_o);
         seen_sync += int'(sync_o);
      end
   end

   // ---------------- stimulus ----------------
   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         cmd = v[i];
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd = 1'b0;
      end
   endtask

   task automatic c_trig();           send_bits(32'b1101, 4); endtask
   task automatic c_sync();           send_bits(32'b1011_0001, 8); endtask
   task automatic c_gres();           send_bits(32'b1011_0010, 8); endtask
   task automatic c_rd(input int a);  send_bits({24'b1011_1000, 4'(a)}, 12); endtask
   task automatic c_wr(input int a, input int d);
      send_bits({4'b1011, 4'b0100, 4'(a), 16'(d)}, 28);
   endtask

   task automatic check_all_zero(input string what);
      chk({sync_o, gres_o, wr_o, rd_o, trig_o, l1_o} == 6'b0, "R1",
          {what, " strobes"}, {sync_o, gres_o, wr_o, rd_o, trig_o, l1_o}, 0);
      chk(addr_o == '0 && data_o == '0, "R1", {what, " addr/data"},
          {addr_o, data_o}, 0);
   endtask

   int base;

   initial begin
      // R1: outputs held at zero while in reset
      repeat (3) @(negedge clk);
      check_all_zero("in reset");
      rst_n = 1'b1;
      idle(5);   // R11: zeros in idle do nothing (compared every cycle)

      c_sync();
      @(negedge clk); cmd = 1'b0;
      chk(sync_o == 1'b1, "R5", "sync strobe after opcode", sync_o, 1);
      c_gres(); idle(2);
      c_wr(5, 16'hA5C3); idle(3);
      c_rd(9); idle(3);

      // R3 and R4: single trigger, then its level-1 pulse
      c_trig();
      @(negedge clk); cmd = 1'b0;
      chk(trig_o == 1'b1, "R3", "trig strobe", trig_o, 1);
      repeat (5) @(negedge clk);
      chk(l1_o == 1'b1, "R4", "l1 at eighth edge", l1_o, 1);
      idle(3);

      // R4: earlier pulse coincides with a later trigger strobe
      c_trig(); send_bits(32'b0, 1); c_trig();
      @(negedge clk); cmd = 1'b0;
      chk(trig_o && l1_o, "R4", "l1 with second trig", {trig_o, l1_o}, 2'b11);
      idle(8);

      // R8: global reset, then a trigger on the very next edge
      c_gres(); c_trig();
      @(negedge clk); cmd = 1'b0;
      chk(trig_o == 1'b1, "R8", "trigger right after global reset", trig_o, 1);
      idle(8);
      c_wr(4'hC, 16'h0F31); c_rd(3); idle(4);

      // R1: asynchronous reset in the middle of a write
      send_bits(32'b1011_0100_0011, 12);
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1 check_all_zero("mid-cycle reset");
      @(negedge clk); rst_n = 1'b1; cmd = 1'b0;
      c_rd(6);
      @(negedge clk); cmd = 1'b0;
      chk(rd_o == 1'b1 && addr_o == 4'd6, "R1", "read after reset",
          {rd_o, addr_o}, {1'b1, 4'd6});
      idle(4);

      // R9: bad prefix 111 locks; commands in lockout ignored
      send_bits(32'b1111, 4);
      base = seen_strobes;
      c_gres(); c_trig(); c_sync(); idle(20);
      while (m_wd != 0) begin
         @(negedge clk); cmd = 1'b0;
      end
      chk(seen_strobes == base, "R9", "strobes during lockout", seen_strobes - base, 0);
      // R10 and R2: a 1 on the wrap edge is dropped, the trigger after it decodes
      cmd = 1'b1;
      c_trig();
      @(negedge clk); cmd = 1'b0;
      chk(trig_o == 1'b1, "R10", "trigger after wrap exit", trig_o, 1);
      chk(m_cyc > 65536, "R2", "lockout spans a counter lap", m_cyc, 65537);
      idle(8);

      // R9: unknown opcode 0111 locks
      send_bits(32'b1011_0111, 8);
      base = seen_sync;
      c_sync(); idle(4);
      while (m_wd != 0) begin
         @(negedge clk); cmd = 1'b0;
      end
      chk(seen_sync == base, "R9", "sync ignored in lockout", seen_sync - base, 0);
      @(negedge clk); cmd = 1'b0;   // wrap edge
      c_sync();
      @(negedge clk); cmd = 1'b0;
      chk(sync_o == 1'b1, "R10", "sync starting after wrap edge", sync_o, 1);
      idle(10);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog expired: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule